// File: doc/BRIEF.md
# Distributed Daisy-Chain Output Arbiter Node

This block is one link in a vertical chain of arbitration nodes that together share a single output line. Each node keeps two queues. The local queue holds cells entering the fabric at this node. The transit queue holds cells passed down from the node above. Once per cell time (one clock cycle here), the node forwards at most one cell to the node below. In the last node of the chain, that output is the output line itself.

Arbitration signals only travel between neighbouring nodes, so the time needed to decide does not grow with the length of the chain. Each local cell is stamped with the value of a free-running cell-time counter when it is written. When both queues are waiting, the cell with the greater age is sent, so cells leave in roughly global age order. A node whose transit queue is nearly full raises a back-off flag to the node above. The threshold leaves room for one cell that may already be on its way.

Top module: `dcarb_node`

## Requirements
- R1: While reset is high and in the first cycle after it, `dn_valid`, `up_nack` and `loc_full` are all low, and both queues are empty.
- R2: A cell on `loc_data` is stored when `loc_valid` is high at a clock edge and `loc_full` is low. It is tagged with the cell-time counter value at that edge. The counter is 0 at the first edge after reset and rises by one (mod 2^TSW) on every edge. A local cell offered while `loc_full` is high is dropped.
- R3: An upstream cell is stored when `up_valid` is high at an edge and the transit queue is not full. It keeps the `up_stamp` it arrived with.
- R4: `up_nack` is high exactly when transit occupancy is at least TD-1. It reflects the occupancy after the most recent edge.
- R5: If `dn_nack` is high at an edge, no cell is sent: `dn_valid` is low after that edge and both queues keep their cells.
- R6: With `dn_nack` low and exactly one queue holding a cell, that queue's oldest cell is sent. A cell written at edge e can be sent at edge e+1 at the earliest. `dn_valid`, `dn_data` and `dn_stamp` are registered and hold it for the cycle after the sending edge. When both queues are empty, `dn_valid` is low.
- R7: With both queues holding a cell, the head with the larger age is sent. Age is (counter - stamp) mod 2^TSW. On equal ages, the transit head is sent.
- R8: At most one cell leaves per edge. Each queue releases its cells in arrival order, with data and stamp unchanged.
- R9: `loc_full` is high exactly when the local queue holds LD cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one edge per cell time |
| rst | input | 1 | Synchronous active-high reset |
| loc_valid | input | 1 | Local cell offered this cycle |
| loc_data | input | DW | Local cell payload |
| loc_full | output | 1 | Local queue holds LD cells |
| up_valid | input | 1 | Cell arriving from the node above |
| up_data | input | DW | Upstream cell payload |
| up_stamp | input | TSW | Entry timestamp of the upstream cell |
| up_nack | output | 1 | Back-off request to the node above |
| dn_valid | output | 1 | Cell sent to the node below or output line |
| dn_data | output | DW | Payload of the sent cell |
| dn_stamp | output | TSW | Entry timestamp of the sent cell |
| dn_nack | input | 1 | Back-off request from the node below |

## Verification
Each rising edge takes in new cells and makes a sending decision based on the queue state from before that edge. A decision made at edge e appears on the `dn_*` ports during the cycle that follows. `up_nack` and `loc_full` change in the cycle after the write or removal that crosses their threshold. A cell written at edge e can leave at edge e+1 at the earliest, so it shows on `dn_*` after that edge. The bench updates a queue-based behavioural model on each rising edge using the same rules. It compares every output at the following falling edge, so each expected value is checked in exactly the cycle it is due.

// File: rtl/dcarb_pkg.sv
package dcarb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_LOCAL   = 2'd1,
    SRC_TRANSIT = 2'd2
  } src_e;
endpackage

// File: rtl/dcarb_fifo.sv
module dcarb_fifo #(
  parameter int W     = 24,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign count   = cnt;
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: the arbiter never removes a cell from an empty queue
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

  // R8: occupancy never exceeds the storage
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: rtl/dcarb_pick.sv
module dcarb_pick
  import dcarb_pkg::*;
#(
  parameter int TSW = 8
) (
  input  logic [TSW-1:0] now,
  input  logic           hold,
  input  logic           l_ok,
  input  logic [TSW-1:0] l_stamp,
  input  logic           t_ok,
  input  logic [TSW-1:0] t_stamp,
  output src_e           pick
);
  logic [TSW-1:0] l_age, t_age;

  assign l_age = now - l_stamp;
  assign t_age = now - t_stamp;

  always_comb begin
    if (hold)
      pick = SRC_NONE;
    else if (l_ok && t_ok)
      pick = (t_age >= l_age) ? SRC_TRANSIT : SRC_LOCAL;
    else if (t_ok)
      pick = SRC_TRANSIT;
    else if (l_ok)
      pick = SRC_LOCAL;
    else
      pick = SRC_NONE;
  end
endmodule

// File: rtl/dcarb_node.sv
module dcarb_node
  import dcarb_pkg::*;
#(
  parameter int DW  = 16,
  parameter int TSW = 8,
  parameter int LD  = 4,
  parameter int TD  = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           loc_valid,
  input  logic [DW-1:0]  loc_data,
  output logic           loc_full,
  input  logic           up_valid,
  input  logic [DW-1:0]  up_data,
  input  logic [TSW-1:0] up_stamp,
  output logic           up_nack,
  output logic           dn_valid,
  output logic [DW-1:0]  dn_data,
  output logic [TSW-1:0] dn_stamp,
  input  logic           dn_nack
);
  localparam int CELLW = DW + TSW;
  localparam int LCW   = $clog2(LD + 1);
  localparam int TCW   = $clog2(TD + 1);

  logic [TSW-1:0]   stamp_cnt;
  logic [CELLW-1:0] l_head, t_head;
  logic [LCW-1:0]   l_cnt;
  logic [TCW-1:0]   t_cnt;
  logic             l_empty, t_empty, l_full, t_full;
  logic             pop_loc, pop_tr;
  src_e             pick;

  always_ff @(posedge clk) begin
    if (rst) stamp_cnt <= '0;
    else     stamp_cnt <= stamp_cnt + 1'b1;
  end

  dcarb_fifo #(.W(CELLW), .DEPTH(LD)) u_loc (
    .clk(clk), .rst(rst),
    .wr_en(loc_valid), .wr_data({loc_data, stamp_cnt}),
    .rd_en(pop_loc), .rd_data(l_head),
    .count(l_cnt), .empty(l_empty), .full(l_full)
  );

  dcarb_fifo #(.W(CELLW), .DEPTH(TD)) u_tr (
    .clk(clk), .rst(rst),
    .wr_en(up_valid), .wr_data({up_data, up_stamp}),
    .rd_en(pop_tr), .rd_data(t_head),
    .count(t_cnt), .empty(t_empty), .full(t_full)
  );

  dcarb_pick #(.TSW(TSW)) u_pick (
    .now(stamp_cnt), .hold(dn_nack),
    .l_ok(!l_empty), .l_stamp(l_head[TSW-1:0]),
    .t_ok(!t_empty), .t_stamp(t_head[TSW-1:0]),
    .pick(pick)
  );

  assign pop_loc  = (pick == SRC_LOCAL);
  assign pop_tr   = (pick == SRC_TRANSIT);
  assign loc_full = l_full;
  assign up_nack  = (t_cnt >= TCW'(TD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
      dn_stamp <= '0;
    end else begin
      dn_valid <= pop_loc || pop_tr;
      if (pop_tr) begin
        dn_data  <= t_head[CELLW-1:TSW];
        dn_stamp <= t_head[TSW-1:0];
      end else if (pop_loc) begin
        dn_data  <= l_head[CELLW-1:TSW];
        dn_stamp <= l_head[TSW-1:0];
      end
    end
  end

  // R5: back-off from below suppresses the next output cell
  assert_nack_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    dn_nack |=> !dn_valid);

  // R6: nothing queued means nothing sent
  assert_idle_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (l_empty && t_empty) |=> !dn_valid);

  // R8: one cell per cell time
  assert_single_grant_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pop_loc, pop_tr}));

  // R7: a local win over a waiting transit head needs a strictly older local cell
  assert_older_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_loc && !t_empty) |->
      (TSW'(stamp_cnt - l_head[TSW-1:0]) > TSW'(stamp_cnt - t_head[TSW-1:0])));

  // R4: back-off is raised before the transit queue can be full
  assert_nack_before_full_R4: assert property (@(posedge clk) disable iff (rst)
    t_full |-> up_nack);

  // R9: local occupancy stays within its depth
  assert_loc_bound_R9: assert property (@(posedge clk) disable iff (rst)
    l_cnt <= LCW'(LD));
endmodule

// File: tb/tb_dcarb_node.sv
module tb_dcarb_node;
  localparam int CLK_P = 10;
  localparam int DW  = 16;
  localparam int TSW = 8;
  localparam int LD  = 4;
  localparam int TD  = 3;
  localparam int MW  = DW + TSW;

  logic           clk = 1'b0;
  logic           rst;
  logic           loc_valid;
  logic [DW-1:0]  loc_data;
  logic           loc_full;
  logic           up_valid;
  logic [DW-1:0]  up_data;
  logic [TSW-1:0] up_stamp;
  logic           up_nack;
  logic           dn_valid;
  logic [DW-1:0]  dn_data;
  logic [TSW-1:0] dn_stamp;
  logic           dn_nack;

  dcarb_node #(.DW(DW), .TSW(TSW), .LD(LD), .TD(TD)) dut (
    .clk(clk), .rst(rst),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_full(loc_full),
    .up_valid(up_valid), .up_data(up_data), .up_stamp(up_stamp),
    .up_nack(up_nack),
    .dn_valid(dn_valid), .dn_data(dn_data), .dn_stamp(dn_stamp),
    .dn_nack(dn_nack)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // behavioural reference model
  logic [MW-1:0]  lq[$];
  logic [MW-1:0]  tq[$];
  int             mcnt = 0;
  logic           e_valid = 0, e_nack = 0, e_full = 0;
  logic [DW-1:0]  e_data = '0;
  logic [TSW-1:0] e_stamp = '0;
  string          e_tag = "R1", e_src = "R2";

  always @(posedge clk) begin
    if (rst) begin
      lq.delete(); tq.delete();
      mcnt = 0; e_valid = 0; e_data = '0; e_stamp = '0; e_tag = "R1";
    end else begin
      bit lfull, tfull, take_t;
      int la, ta;
      logic [MW-1:0] item;
      lfull = lq.size() >= LD;
      tfull = tq.size() >= TD;
      e_valid = 0;
      if (lq.size() == 0 && tq.size() == 0) e_tag = "R6";
      else if (dn_nack) e_tag = "R5";
      else begin
        if (lq.size() > 0 && tq.size() > 0) begin
          la = (mcnt - int'(lq[0][TSW-1:0])) & ((1 << TSW) - 1);
          ta = (mcnt - int'(tq[0][TSW-1:0])) & ((1 << TSW) - 1);
          take_t = (ta >= la);
          e_tag = "R7";
        end else begin
          take_t = (tq.size() > 0);
          e_tag = "R6";
        end
        if (take_t) begin item = tq.pop_front(); e_src = "R3"; end
        else        begin item = lq.pop_front(); e_src = "R2"; end
        e_valid = 1;
        e_data  = item[MW-1:TSW];
        e_stamp = item[TSW-1:0];
      end
      if (loc_valid && !lfull) lq.push_back({loc_data, TSW'(mcnt)});
      if (up_valid && !tfull)  tq.push_back({up_data, up_stamp});
      mcnt = (mcnt + 1) % (1 << TSW);
    end
    e_nack = (tq.size() >= TD - 1);
    e_full = (lq.size() == LD);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(e_tag, 32'(dn_valid), 32'(e_valid));
    if (e_valid) begin
      chk("R8 data", 32'(dn_data), 32'(e_data));
      chk(e_src, 32'(dn_stamp), 32'(e_stamp));
    end
    chk("R4", 32'(up_nack), 32'(e_nack));
    chk("R9", 32'(loc_full), 32'(e_full));
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; loc_valid = 0; loc_data = '0; up_valid = 0; up_data = '0;
    up_stamp = '0; dn_nack = 0;
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1: quiet outputs right after reset
    chk("R1", {29'd0, dn_valid, up_nack, loc_full}, 32'd0);

    // R6: local-only traffic
    for (int i = 0; i < 7; i++) begin
      loc_valid = (i < 5); loc_data = DW'(16'h10 + i);
      step();
    end
    loc_valid = 0;

    // R5/R9/R4: blocked below, fill both queues, extra local cells dropped (R2)
    dn_nack = 1;
    for (int i = 0; i < 8; i++) begin
      loc_valid = 1; loc_data = DW'(16'h100 + i);
      up_valid = !up_nack; up_data = DW'(16'h200 + i);
      up_stamp = TSW'(mcnt - 3 * i);
      step();
    end
    loc_valid = 0; up_valid = 0;
    step();

    // R7: release, both queues compete by age
    dn_nack = 0;
    repeat (10) step();

    // R7 tie: same stamp in both queues, transit must go first
    dn_nack = 1;
    loc_valid = 1; loc_data = DW'(16'hAAAA);
    up_valid = 1; up_data = DW'(16'hBBBB); up_stamp = TSW'(mcnt);
    step();
    loc_valid = 0; up_valid = 0;
    step();
    dn_nack = 0;
    repeat (4) step();

    // mixed random traffic, including stamp wrap-around
    for (int i = 0; i < 3000; i++) begin
      loc_valid = ($urandom_range(0, 99) < 45);
      loc_data  = DW'($urandom);
      up_valid  = !up_nack && ($urandom_range(0, 99) < 50);
      up_data   = DW'($urandom);
      up_stamp  = TSW'(mcnt - $urandom_range(0, 20));
      dn_nack   = ($urandom_range(0, 99) < 25);
      step();
    end
    loc_valid = 0; up_valid = 0; dn_nack = 0;
    repeat (12) step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule